// File: doc/BRIEF.md
# Register-Fed Multi-Operation Reconfigurable Unit

This block is a reconfigurable functional unit that sits beside a processor's register file. It watches a live copy of every register, so its datapath starts computing on a value as soon as that value is written. Up to four custom operations are resident at once. Each one occupies a slot: a group of rows that holds its own operation tag. Each row takes its operands from register values or from earlier rows of the same slot. The last row of a slot produces that slot's result.

When the processor issues a custom operation, the unit compares the operation tag against the resident tags. On a hit it registers the matching slot's result, but only once every register that slot reads is ready. It tracks readiness per register from a write-pending strobe and a write-landing strobe. On a miss it stalls the processor and picks the least recently used slot as the victim. It invalidates that slot's tag at once, fetches the slot's configuration words one per row from a configuration memory with one cycle of read latency, and then validates the new tag. The held issue then completes as a hit.

Top module: `rfu_unit`

## Requirements
- R1: After reset, `stall`, `done`, `cfg_req` and every bit of `slot_valid` are low.
- R2: A configuration word has operand A select in bits [3:0], operand B select in bits [7:4] and the row function in bits [10:8]. For a select, bit 3 = 0 picks register select[2:0]. Bit 3 = 1 picks the output of row select[2:0] of the same slot if that row is an earlier one, and zero otherwise. The functions are 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 A<<B[4:0], 6 A and 7 ~A. A slot's result is the output of its last row.
- R3: On an issue whose tag is resident, with every register the slot reads ready, `stall` is low in the issue cycle. `done` is high in the next cycle, with `result` equal to the slot's value computed from the register values of the issue cycle.
- R4: A register's ready bit clears on the edge after its pending strobe (without a write strobe), and sets on the edge after its write strobe. A resident operation stalls while any register it reads is not ready. A write landing in the issue cycle therefore costs at least one extra cycle. A register that the slot does not read has no effect.
- R5: A miss keeps `stall` high for exactly ROWS+2 cycles (4 with defaults), counting the issue cycle. The operation then completes as in R3.
- R6: During a reload `cfg_req` is high for exactly ROWS cycles. `cfg_addr` is {tag, row index}, with the row index counting up from 0. The word is taken from `cfg_rdata` in the cycle after each request.
- R7: The victim is the least recently used slot. Both a completion and a finished reload count as use. Out of reset, slots are filled in the order 0, 1, 2, 3. The victim's `slot_valid` bit is low from the cycle after the miss until its last word is written.
- R8: Up to NSLOT different tags stay resident together, and `slot_valid` shows which slots hold a loaded operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_vals | input | NREG*W | Live register copies, register i at bits [i*W +: W] |
| reg_pend | input | NREG | Write to register i is pending |
| reg_wr | input | NREG | Write to register i lands this cycle |
| issue | input | 1 | Custom operation issued, held while stalled |
| issue_tag | input | TAGW | Tag of the issued operation |
| stall | output | 1 | Processor must hold the issue |
| done | output | 1 | Result valid (one cycle) |
| result | output | W | Result of the completed operation |
| slot_valid | output | NSLOT | Slot holds a loaded operation |
| cfg_req | output | 1 | Configuration word read request |
| cfg_addr | output | TAGW+log2(ROWS) | Configuration word address {tag, row} |
| cfg_rdata | input | 2*(log2(NREG)+1)+3 | Configuration word, one cycle after the request |

## Verification
A corrupted tag table shows within the issue cycle. A wrong hit or miss changes the stall length from zero to ROWS+2 cycles, or the reverse, and a stale match returns a wrong `result` on the next cycle. A wrong recency order shows as an unexpected miss on a later issue, together with the wrong `slot_valid` bit dropping one cycle after the miss. Wrong readiness or usage tracking changes the stall count of an operation by at least one cycle. A bad row selection or function shows as a `result` mismatch on the cycle after completion.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_PSA = 3'd6,
    OP_NOT = 3'd7
  } row_op_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_LOAD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rfu_ready.sv
module rfu_ready #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] pend,
  input  logic [NREG-1:0] wr,
  output logic [NREG-1:0] rdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= '1;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr[i])        rdy[i] <= 1'b1;
        else if (pend[i]) rdy[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_set_after_write_r4: assert property (@(posedge clk) disable iff (rst)
      wr[g] |=> rdy[g]);
    p_clear_on_pending_r4: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && !wr[g]) |=> !rdy[g]);
  end
endmodule

// File: rtl/rfu_slot.sv
module rfu_slot
  import rfu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = 32,
  parameter int ROWS = 2,
  localparam int RIW = $clog2(NREG),
  localparam int SW  = RIW + 1,
  localparam int CW  = 2 * SW + 3,
  localparam int IW  = $clog2(ROWS),
  localparam int SHW = $clog2(W)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [CW-1:0]             wdata,
  input  logic [NREG-1:0][W-1:0]    regs,
  output logic [W-1:0]              value,
  output logic [NREG-1:0]           used
);
  logic [CW-1:0] cfg [ROWS];
  logic [W-1:0]  rv  [ROWS];

  always_ff @(posedge clk) begin
    if (we) cfg[widx] <= wdata;
  end

  always_comb begin
    logic [SW-1:0] sa, sb;
    logic [W-1:0]  a, b;
    row_op_e       op;
    rv = '{default: '0};
    for (int k = 0; k < ROWS; k++) begin
      sa = cfg[k][SW-1:0];
      sb = cfg[k][2*SW-1:SW];
      op = row_op_e'(cfg[k][CW-1 -: 3]);
      a  = '0;
      b  = '0;
      if (!sa[SW-1]) a = regs[sa[RIW-1:0]];
      else
        for (int j = 0; j < ROWS; j++)
          if (j < k && sa[RIW-1:0] == RIW'(j)) a = rv[j];
      if (!sb[SW-1]) b = regs[sb[RIW-1:0]];
      else
        for (int j = 0; j < ROWS; j++)
          if (j < k && sb[RIW-1:0] == RIW'(j)) b = rv[j];
      case (op)
        OP_ADD:  rv[k] = a + b;
        OP_SUB:  rv[k] = a - b;
        OP_AND:  rv[k] = a & b;
        OP_OR:   rv[k] = a | b;
        OP_XOR:  rv[k] = a ^ b;
        OP_SHL:  rv[k] = a << b[SHW-1:0];
        OP_PSA:  rv[k] = a;
        default: rv[k] = ~a;
      endcase
    end
  end

  always_comb begin
    used = '0;
    for (int k = 0; k < ROWS; k++) begin
      if (!cfg[k][SW-1])   used[cfg[k][RIW-1:0]] = 1'b1;
      if (!cfg[k][2*SW-1]) used[cfg[k][SW+RIW-1:SW]] = 1'b1;
    end
  end

  assign value = rv[ROWS-1];
endmodule

// File: rtl/rfu_lru.sv
module rfu_lru #(
  parameter int NSLOT = 4,
  localparam int SIW  = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           touch,
  input  logic [SIW-1:0] touch_idx,
  output logic [SIW-1:0] victim
);
  logic [SIW-1:0]   age [NSLOT];
  logic [NSLOT-1:0] oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) age[i] <= SIW'(NSLOT - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (SIW'(i) == touch_idx)     age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NSLOT; i++) begin
      oldest[i] = (age[i] == SIW'(NSLOT - 1));
      if (oldest[i]) victim = SIW'(i);
    end
  end

  p_single_oldest_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest));
endmodule

// File: rtl/rfu_unit.sv
module rfu_unit
  import rfu_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int W     = 32,
  parameter int NSLOT = 4,
  parameter int TAGW  = 4,
  parameter int ROWS  = 2,
  localparam int RIW  = $clog2(NREG),
  localparam int SW   = RIW + 1,
  localparam int CW   = 2 * SW + 3,
  localparam int IW   = $clog2(ROWS),
  localparam int SIW  = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREG*W-1:0]    reg_vals,
  input  logic [NREG-1:0]      reg_pend,
  input  logic [NREG-1:0]      reg_wr,
  input  logic                 issue,
  input  logic [TAGW-1:0]      issue_tag,
  output logic                 stall,
  output logic                 done,
  output logic [W-1:0]         result,
  output logic [NSLOT-1:0]     slot_valid,
  output logic                 cfg_req,
  output logic [TAGW+IW-1:0]   cfg_addr,
  input  logic [CW-1:0]        cfg_rdata
);
  localparam logic [IW:0]   NROWS = (IW+1)'(ROWS);
  localparam logic [IW-1:0] LAST  = IW'(ROWS - 1);

  logic [NREG-1:0][W-1:0] regs;
  logic [NREG-1:0]        rdy;
  logic [TAGW-1:0]        tag_q [NSLOT];
  logic [NSLOT-1:0]       valid_q, hit_vec;
  logic [SIW-1:0]         hit_idx, victim_q, lru_victim;
  logic [W-1:0]           slot_res [NSLOT];
  logic [NREG-1:0]        slot_used [NSLOT];
  logic                   hit, ops_ready, fire, start, last_wr, touch;
  seq_state_e             state_q;
  logic [TAGW-1:0]        ld_tag;
  logic [IW:0]            req_cnt;
  logic                   r_vld;
  logic [IW-1:0]          r_idx;

  assign regs = reg_vals;

  rfu_ready #(.NREG(NREG)) u_ready (
    .clk(clk), .rst(rst), .pend(reg_pend), .wr(reg_wr), .rdy(rdy)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    rfu_slot #(.NREG(NREG), .W(W), .ROWS(ROWS)) u_slot (
      .clk(clk), .we(r_vld && victim_q == SIW'(s)), .widx(r_idx),
      .wdata(cfg_rdata), .regs(regs), .value(slot_res[s]), .used(slot_used[s])
    );
    assign hit_vec[s] = valid_q[s] && (tag_q[s] == issue_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NSLOT; i++) if (hit_vec[i]) hit_idx = SIW'(i);
  end

  assign hit       = |hit_vec;
  assign ops_ready = &(rdy | ~slot_used[hit_idx]);
  assign fire      = issue && state_q == S_IDLE && hit && ops_ready;
  assign start     = issue && state_q == S_IDLE && !hit;
  assign stall     = issue && !fire;
  assign last_wr   = r_vld && r_idx == LAST;
  assign touch     = fire || last_wr;
  assign cfg_req   = state_q == S_LOAD && req_cnt < NROWS;
  assign cfg_addr  = {ld_tag, req_cnt[IW-1:0]};
  assign slot_valid = valid_q;

  rfu_lru #(.NSLOT(NSLOT)) u_lru (
    .clk(clk), .rst(rst), .touch(touch),
    .touch_idx(fire ? hit_idx : victim_q), .victim(lru_victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      valid_q  <= '0;
      victim_q <= '0;
      ld_tag   <= '0;
      req_cnt  <= '0;
      r_vld    <= 1'b0;
      r_idx    <= '0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done  <= fire;
      if (fire) result <= slot_res[hit_idx];
      r_vld <= cfg_req;
      r_idx <= req_cnt[IW-1:0];
      if (cfg_req) req_cnt <= req_cnt + 1'b1;
      if (start) begin
        state_q <= S_LOAD;
        victim_q <= lru_victim;
        valid_q[lru_victim] <= 1'b0;
        ld_tag  <= issue_tag;
        req_cnt <= '0;
      end
      if (last_wr) begin
        tag_q[victim_q]   <= ld_tag;
        valid_q[victim_q] <= 1'b1;
        state_q <= S_IDLE;
      end
    end
  end

  p_hit_unique_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  p_victim_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    state_q == S_LOAD |-> !valid_q[victim_q]);
  p_done_after_issue_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(issue));
  p_no_result_while_loading_r5: assert property (@(posedge clk) disable iff (rst)
    state_q == S_LOAD |=> !done);
endmodule

// File: tb/sim_rfu_unit.sv
module sim_rfu_unit;
  localparam int NREG = 8, W = 32, NSLOT = 4, TAGW = 4, ROWS = 2;
  localparam int IW = 1, CW = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic [NREG*W-1:0] reg_vals;
  logic [NREG-1:0] reg_pend = '0, reg_wr = '0;
  logic issue = 1'b0;
  logic [TAGW-1:0] issue_tag = '0;
  logic stall, done, cfg_req;
  logic [W-1:0] result;
  logic [NSLOT-1:0] slot_valid;
  logic [TAGW+IW-1:0] cfg_addr;
  logic [CW-1:0] cfg_rdata = '0;

  logic [W-1:0] rg [NREG];
  int m_tag [NSLOT];
  bit m_val [NSLOT];
  int stamp [NSLOT];
  int stampc = 100;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NREG; i++) reg_vals[i*W +: W] = rg[i];

  rfu_unit u0 (
    .clk(clk), .rst(rst), .reg_vals(reg_vals), .reg_pend(reg_pend), .reg_wr(reg_wr),
    .issue(issue), .issue_tag(issue_tag), .stall(stall), .done(done), .result(result),
    .slot_valid(slot_valid), .cfg_req(cfg_req), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [CW-1:0] cfgw(int tag, int row);
    logic [3:0] sa, sb;
    logic [2:0] op;
    sa = (row == 1 && tag % 2 == 1) ? 4'b1000 : {1'b0, 3'(tag * 3 + row * 5 + 1)};
    sb = {1'b0, 3'(tag * 5 + row * 3 + 2)};
    op = 3'(tag + row * 3);
    return {op, sb, sa};
  endfunction

  // R2 field layout: [3:0] A select, [7:4] B select, [10:8] function
  function automatic logic [W-1:0] pick(logic [3:0] s, int k, logic [W-1:0] r0);
    if (!s[3]) return rg[s[2:0]];
    if (s[2:0] == 3'd0 && k > 0) return r0;
    return '0;
  endfunction

  function automatic logic [W-1:0] alu(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return a;
      default: return ~a;
    endcase
  endfunction

  function automatic logic [W-1:0] model(int tag);
    logic [W-1:0] r0, r1;
    logic [CW-1:0] w0, w1;
    w0 = cfgw(tag, 0);
    w1 = cfgw(tag, 1);
    r0 = alu(w0[10:8], pick(w0[3:0], 0, '0), pick(w0[7:4], 0, '0));
    r1 = alu(w1[10:8], pick(w1[3:0], 1, r0), pick(w1[7:4], 1, r0));
    return r1;
  endfunction

  function automatic logic [NREG-1:0] uses(int tag);
    logic [NREG-1:0] u = '0;
    for (int k = 0; k < ROWS; k++) begin
      logic [CW-1:0] w = cfgw(tag, k);
      if (!w[3]) u[w[2:0]] = 1'b1;
      if (!w[7]) u[w[6:4]] = 1'b1;
    end
    return u;
  endfunction

  function automatic logic [NSLOT-1:0] vmask();
    logic [NSLOT-1:0] m = '0;
    for (int i = 0; i < NSLOT; i++) m[i] = m_val[i];
    return m;
  endfunction

  always @(posedge clk) cfg_rdata <= cfgw(int'(cfg_addr[TAGW+IW-1:IW]), int'(cfg_addr[IW-1:0]));

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Issue one operation with all registers ready; checks stall length, fetch and result.
  task automatic do_op(int tag);
    int slot = -1, v = 0, n = 0, reqs = 0, exp_n;
    bit miss;
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_tag[i] == tag) slot = i;
    miss = (slot < 0);
    if (miss) begin
      for (int i = 1; i < NSLOT; i++) if (stamp[i] < stamp[v]) v = i;
      exp_n = ROWS + 2;
    end else exp_n = 0;
    @(negedge clk);
    issue = 1'b1;
    issue_tag = TAGW'(tag);
    #1;
    while (stall && n < 50) begin
      if (cfg_req) begin
        chk(cfg_addr == {TAGW'(tag), IW'(reqs)}, "R6 cfg_addr", W'(cfg_addr), W'({TAGW'(tag), IW'(reqs)}));
        reqs++;
      end
      if (miss && n == 1) chk(slot_valid[v] == 1'b0, "R7 victim invalid", W'(slot_valid), W'(v));
      @(negedge clk);
      #1;
      n++;
    end
    chk(n == exp_n, miss ? "R5 miss stall cycles" : "R3 hit stall cycles", W'(n), W'(exp_n));
    if (miss) begin
      chk(reqs == ROWS, "R6 request count", W'(reqs), W'(ROWS));
      m_tag[v] = tag;
      m_val[v] = 1'b1;
      slot = v;
    end
    stamp[slot] = stampc++;
    @(negedge clk);
    issue = 1'b0;
    #1;
    chk(done == 1'b1, "R3 done", W'(done), 1);
    chk(result == model(tag), "R2 result", result, model(tag));
    chk(slot_valid == vmask(), "R8 slot_valid", W'(slot_valid), W'(vmask()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    int n, r, tag;
    logic [NREG-1:0] u;
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) rg[i] = $urandom;
    for (int i = 0; i < NSLOT; i++) begin
      m_val[i] = 1'b0; m_tag[i] = -1; stamp[i] = i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!stall && !done && !cfg_req && slot_valid == '0, "R1 reset state",
        W'({stall, done, cfg_req, slot_valid}), 0);

    // fill order 0,1,2,3 (R7, R8)
    for (int t = 0; t < 4; t++) do_op(t);
    chk(slot_valid == 4'b1111, "R8 all resident", W'(slot_valid), 32'hf);
    do_op(2);
    do_op(1);
    do_op(5);   // evicts least recently used (R7)
    do_op(0);   // miss again
    do_op(5);

    // late input: write lands in a stalled cycle (R4)
    tag = 1;
    do_op(tag);
    u = uses(tag);
    r = 0;
    for (int i = NREG - 1; i >= 0; i--) if (u[i]) r = i;
    @(negedge clk); reg_pend[r] = 1'b1;
    @(negedge clk); issue = 1'b1; issue_tag = TAGW'(tag); #1;
    chk(stall == 1'b1, "R4 stall on pending", W'(stall), 1);
    @(negedge clk); #1;
    chk(stall == 1'b1, "R4 still stalled", W'(stall), 1);
    @(negedge clk); reg_pend[r] = 1'b0; reg_wr[r] = 1'b1; rg[r] = rg[r] + 32'h1357; #1;
    chk(stall == 1'b1, "R4 write cycle stalls", W'(stall), 1);
    @(negedge clk); reg_wr[r] = 1'b0; #1;
    chk(stall == 1'b0, "R4 ready after write", W'(stall), 0);
    @(negedge clk); issue = 1'b0; #1;
    chk(done == 1'b1 && result == model(tag), "R4 result with new value", result, model(tag));
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_tag[i] == tag) stamp[i] = stampc++;

    // write landed one cycle before issue: no stall (R3, R4)
    @(negedge clk); reg_pend[r] = 1'b1;
    @(negedge clk); reg_pend[r] = 1'b0; reg_wr[r] = 1'b1; rg[r] = ~rg[r];
    @(negedge clk); reg_wr[r] = 1'b0; issue = 1'b1; issue_tag = TAGW'(tag); #1;
    chk(stall == 1'b0, "R4 earlier write no stall", W'(stall), 0);
    @(negedge clk); issue = 1'b0; #1;
    chk(result == model(tag), "R3 result after early write", result, model(tag));
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_tag[i] == tag) stamp[i] = stampc++;

    // pending on a register the slot does not read: no effect (R4)
    r = 0;
    for (int i = NREG - 1; i >= 0; i--) if (!u[i]) r = i;
    @(negedge clk); reg_pend[r] = 1'b1;
    @(negedge clk); issue = 1'b1; issue_tag = TAGW'(tag); #1;
    chk(stall == 1'b0, "R4 unused register ignored", W'(stall), 0);
    @(negedge clk); issue = 1'b0; #1;
    chk(done == 1'b1 && result == model(tag), "R4 unused register result", result, model(tag));
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_tag[i] == tag) stamp[i] = stampc++;
    reg_pend[r] = 1'b0; reg_wr[r] = 1'b1;
    @(negedge clk); reg_wr[r] = 1'b0;

    // constrained random: tags 0..6 over 4 slots
    for (int k = 0; k < 80; k++) begin
      for (int i = 0; i < NREG; i++) rg[i] = $urandom;
      do_op(int'($urandom % 7));
    end

    n = 0;
    summary();
  end
endmodule